// File: doc/BRIEF.md
# Double-Buffered Display Layer Configuration

This block keeps the configuration of every display layer of a panel controller in two register sets. Software writes through a simple register port and reaches only the shadow set. The pixel pipeline sees only the active set, which it receives as one flat output vector. A control register asks for the shadow set to be copied into the active set. The copy can happen at once, or on the next rising edge of the vertical-blanking strobe from the timing generator. Either way, every field of every layer changes in the same clock cycle.

Each finished copy sets a sticky done flag. The flag drives a maskable interrupt. When the active set is loaded, the window coordinates are clamped to the visible area. Writes to a layer's colour lookup-table port go out as a one-cycle write strobe. The block drops that strobe while the active copy of the layer has both the layer and its lookup table enabled.

Top module: `layer_shadow_ctrl`

## Requirements
- R1: After reset, every shadow and active register reads zero, no reload is pending, and `irq`, `lut_we` and the done flag are 0.
- R2: Layer registers sit at address `(layer+1)*16 + offset`, with offsets 0 to 9 (0 control: bit0 layer on, bit1 table on; 1 horizontal window; 2 vertical window; 3 to 9 format, base address, pitch/length, line count, default colour, blend, key). A write changes only the shadow copy, which reads back at the same address. The active copy at bit offset `(layer*10+offset)*DW` in `act_regs` is left unchanged.
- R3: Writing 1 to bit0 of the control word at address 0 requests an immediate reload. Bit0 reads 1 in the cycle after the write. At the next edge every active register takes its shadow value, and bit0 clears.
- R4: Writing 1 to bit1 at address 0 (with bit0 at 0) arms a blanking reload, which reads back as bit1. The copy takes place on the edge where `vblank` is first sampled high after having been low, and bit1 then clears. A `vblank` that stays high does not start a copy.
- R5: When a register is written more than once before a reload, only the last value reaches the active set.
- R6: An immediate request, whether it arrives alone or together with bit1, cancels any armed blanking reload.
- R7: A write to offset 10 of a layer raises `lut_we` for one cycle after the write, carrying the data and the layer number on `lut_data` and `lut_layer`. The write is dropped when that layer's active control word has both bit0 and bit1 set. The value in the shadow copy does not decide this.
- R8: Every copy sets the done flag, which reads as bit0 at address 1. `irq` equals the flag ANDed with the enable in bit0 at address 2. Writing 1 to bit0 at address 1 clears the flag, and writing 0 has no effect.
- R9: When the active set is loaded, the two 16-bit halves of each window register (start in the low half, stop in the high half) are clamped to `[H_FIRST, H_LAST]` for the horizontal register and `[V_FIRST, V_LAST]` for the vertical one. The shadow copy keeps the value as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data (combinational) |
| vblank | input | 1 | Vertical-blanking level from the timing generator |
| act_regs | output | NL*10*DW | Active layer registers, flattened |
| lut_we | output | 1 | Lookup-table write strobe |
| lut_layer | output | max(1,clog2(NL)) | Layer targeted by the table write |
| lut_data | output | DW | Table write data |
| irq | output | 1 | Reload-done interrupt |

## Verification
The bench builds the block with its defaults: two layers, 32-bit registers, 8-bit addresses, a horizontal window bound of 2 to 41 and a vertical bound of 1 to 20. With bounds this small, a sweep of 64 start and stop values on both window registers crosses the lower bound, the in-range band and the upper bound. Expected values are computed arithmetically. With only two layers, every one of the twenty layer registers can be written twice, checked as unmoved and checked after transfer. All four combinations of the lookup-table lock bits can be tried as well.

// File: rtl/layer_shadow_ctrl.sv
module layer_shadow_ctrl #(
  parameter int NL      = 2,
  parameter int DW      = 32,
  parameter int AW      = 8,
  parameter int H_FIRST = 2,
  parameter int H_LAST  = 41,
  parameter int V_FIRST = 1,
  parameter int V_LAST  = 20,
  localparam int NREG   = 10,
  localparam int LW     = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic [AW-1:0]        rd_addr,
  output logic [DW-1:0]        rd_data,
  input  logic                 vblank,
  output logic [NL*NREG*DW-1:0] act_regs,
  output logic                 lut_we,
  output logic [LW-1:0]        lut_layer,
  output logic [DW-1:0]        lut_data,
  output logic                 irq
);
  localparam int HALF    = DW / 2;
  localparam int PW      = AW - 4;
  localparam int R_CTRL  = 0;
  localparam int R_WINH  = 1;
  localparam int R_WINV  = 2;
  localparam logic [3:0] LUT_OFS = 4'd10;

  logic [DW-1:0] shd [NL][NREG];
  logic [DW-1:0] act [NL][NREG];
  logic pend_imm, pend_vb, vb_q, stat, ien;

  wire [PW-1:0] page   = wr_addr[AW-1:4];
  wire [3:0]    ofs    = wr_addr[3:0];
  wire [PW-1:0] rpage  = rd_addr[AW-1:4];
  wire [3:0]    rofs   = rd_addr[3:0];
  wire          glob_wr = wr_en && (page == '0);
  wire          vb_rise = vblank && !vb_q;
  wire          copy    = pend_imm || (pend_vb && vb_rise);

  function automatic logic [HALF-1:0] clampf(input logic [HALF-1:0] v,
                                             input logic [HALF-1:0] lo,
                                             input logic [HALF-1:0] hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  logic [NL-1:0] lut_hit;

  for (genvar l = 0; l < NL; l++) begin : g_layer
    localparam logic [PW-1:0] PG = PW'(l + 1);
    assign lut_hit[l] = (page == PG) && !(act[l][R_CTRL][0] && act[l][R_CTRL][1]);
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic [DW-1:0] load_val;
      if (r == R_WINH) begin : g_h
        assign load_val = {clampf(shd[l][r][DW-1:HALF], HALF'(H_FIRST), HALF'(H_LAST)),
                           clampf(shd[l][r][HALF-1:0],  HALF'(H_FIRST), HALF'(H_LAST))};
      end else if (r == R_WINV) begin : g_v
        assign load_val = {clampf(shd[l][r][DW-1:HALF], HALF'(V_FIRST), HALF'(V_LAST)),
                           clampf(shd[l][r][HALF-1:0],  HALF'(V_FIRST), HALF'(V_LAST))};
      end else begin : g_p
        assign load_val = shd[l][r];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          shd[l][r] <= '0;
          act[l][r] <= '0;
        end else begin
          if (wr_en && page == PG && ofs == 4'(r)) shd[l][r] <= wr_data;
          if (copy) act[l][r] <= load_val;
        end
      end

      assign act_regs[(l*NREG+r)*DW +: DW] = act[l][r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_imm <= 1'b0;
      pend_vb  <= 1'b0;
      vb_q     <= 1'b0;
      stat     <= 1'b0;
      ien      <= 1'b0;
    end else begin
      vb_q <= vblank;
      if (copy) begin
        pend_imm <= 1'b0;
        pend_vb  <= 1'b0;
      end
      if (glob_wr && ofs == 4'd0) begin
        if (wr_data[0]) begin
          pend_imm <= 1'b1;
          pend_vb  <= 1'b0;
        end else if (wr_data[1]) begin
          pend_vb  <= 1'b1;
        end
      end
      if (glob_wr && ofs == 4'd1 && wr_data[0]) stat <= 1'b0;
      if (copy) stat <= 1'b1;
      if (glob_wr && ofs == 4'd2) ien <= wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lut_we    <= 1'b0;
      lut_layer <= '0;
      lut_data  <= '0;
    end else begin
      lut_we <= wr_en && (ofs == LUT_OFS) && (|lut_hit);
      if (wr_en && ofs == LUT_OFS) begin
        lut_layer <= LW'(page - PW'(1));
        lut_data  <= wr_data;
      end
    end
  end

  assign irq = stat && ien;

  always_comb begin
    rd_data = '0;
    if (rpage == '0) begin
      case (rofs)
        4'd0:    rd_data = DW'({pend_vb, pend_imm});
        4'd1:    rd_data = DW'(stat);
        4'd2:    rd_data = DW'(ien);
        default: rd_data = '0;
      endcase
    end else begin
      for (int l = 0; l < NL; l++)
        for (int r = 0; r < NREG; r++)
          if (rpage == PW'(l + 1) && rofs == 4'(r)) rd_data = shd[l][r];
    end
  end
endmodule

module layer_shadow_ctrl_chk #(
  parameter int NL = 2,
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int H_FIRST = 2,
  parameter int H_LAST  = 41
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [AW-1:0]        wr_addr,
  input logic [DW-1:0]        wr_data,
  input logic                 vblank,
  input logic [NL*10*DW-1:0]  act_regs,
  input logic                 lut_we,
  input logic                 irq,
  input logic                 pend_imm,
  input logic                 pend_vb,
  input logic                 vb_q,
  input logic                 stat
);
  localparam int HALF = DW / 2;
  localparam logic [AW-1:0] LUT0 = {(AW-4)'(1), 4'd10};
  wire          ctl_wr = wr_en && (wr_addr == '0);
  wire [DW-1:0] winh0  = act_regs[DW +: DW];
  wire [1:0]    ctl0   = act_regs[1:0];

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_imm || (pend_vb && vblank && !vb_q)) |=> $stable(act_regs)); // R2
  AST_IMM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_imm && !ctl_wr) |=> (!pend_imm && !pend_vb)); // R3
  AST_VB_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vb && !pend_imm && vblank && !vb_q && !ctl_wr) |=> !pend_vb); // R4
  AST_IMM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wr_data[0]) |=> !pend_vb); // R6
  AST_LUT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == LUT0 && ctl0 == 2'b11) |=> !lut_we); // R7
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pend_imm |=> stat); // R8
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !stat |-> !irq); // R8
  AST_WIN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    pend_imm |=> (winh0[HALF-1:0] >= HALF'(H_FIRST) && winh0[HALF-1:0] <= HALF'(H_LAST) &&
                  winh0[DW-1:HALF] >= HALF'(H_FIRST) && winh0[DW-1:HALF] <= HALF'(H_LAST))); // R9
endmodule

bind layer_shadow_ctrl layer_shadow_ctrl_chk #(
  .NL(NL), .DW(DW), .AW(AW), .H_FIRST(H_FIRST), .H_LAST(H_LAST)
) u_chk (.*);

// File: tb/layer_shadow_ctrl_tb.sv
`timescale 1ns/1ps
module layer_shadow_ctrl_tb;
  localparam int NL = 2, DW = 32, AW = 8, NREG = 10;
  localparam int HF = 2, HL = 41, VF = 1, VL = 20;

  logic clk = 0, rst_n = 0, wr_en = 0, vblank = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data, lut_data;
  logic [NL*NREG*DW-1:0] act_regs;
  logic lut_we, irq;
  logic [0:0] lut_layer;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  layer_shadow_ctrl u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    rd_addr = a; #0.1; v = rd_data;
  endtask

  function automatic logic [31:0] actv(input int l, input int r);
    return act_regs[(l*NREG+r)*DW +: DW];
  endfunction

  function automatic logic [15:0] cl(input logic [15:0] v, input int lo, input int hi);
    if (v < 16'(lo)) return 16'(lo);
    if (v > 16'(hi)) return 16'(hi);
    return v;
  endfunction

  function automatic logic [31:0] expect_act(input int r, input logic [31:0] v);
    if (r == 1) return {cl(v[31:16], HF, HL), cl(v[15:0], HF, HL)};
    if (r == 2) return {cl(v[31:16], VF, VL), cl(v[15:0], VF, VL)};
    return v;
  endfunction

  function automatic logic [7:0] ra(input int l, input int r);
    return 8'((l + 1) * 16 + r);
  endfunction

  task automatic reload_now();
    wr(8'h00, 32'h1);
    @(negedge clk);
  endtask

  logic [31:0] v, keep;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int l = 0; l < NL; l++)
      for (int r = 0; r < NREG; r++) begin
        rd(ra(l, r), v);
        chk(v == 0 && actv(l, r) == 0, "R1 reset regs", v | actv(l, r), 0);
      end
    rd(8'h00, v); chk(v == 0, "R1 no pending", v, 0);
    chk(!irq && !lut_we, "R1 irq/lut idle", {irq, lut_we}, 0);

    // R2 shadow only, R5 overwrite, R3 immediate
    for (int l = 0; l < NL; l++)
      for (int r = 0; r < NREG; r++) begin
        wr(ra(l, r), 32'hDEAD_0000 | 32'(r));
        wr(ra(l, r), {8'(l + 1), 8'(r), 16'(r * 7 + l)});
      end
    for (int l = 0; l < NL; l++)
      for (int r = 0; r < NREG; r++) begin
        rd(ra(l, r), v);
        chk(v == {8'(l + 1), 8'(r), 16'(r * 7 + l)}, "R2 shadow readback", v, {8'(l + 1), 8'(r), 16'(r * 7 + l)});
        chk(actv(l, r) == 0, "R2 active untouched", actv(l, r), 0);
      end
    wr(8'h00, 32'h1);
    rd(8'h00, v); chk(v == 1, "R3 pending visible", v, 1);
    chk(actv(0, 5) == 0, "R3 not yet copied", actv(0, 5), 0);
    @(negedge clk);
    rd(8'h00, v); chk(v == 0, "R3 bit clears", v, 0);
    for (int l = 0; l < NL; l++)
      for (int r = 0; r < NREG; r++)
        chk(actv(l, r) == expect_act(r, {8'(l + 1), 8'(r), 16'(r * 7 + l)}), "R5 latest value loaded",
            actv(l, r), expect_act(r, {8'(l + 1), 8'(r), 16'(r * 7 + l)}));

    // R9 clamp sweep
    for (int s = 0; s < 64; s++) begin
      wr(ra(1, 1), {16'(63 - s), 16'(s)});
      wr(ra(1, 2), {16'(s), 16'(63 - s)});
      reload_now();
      chk(actv(1, 1) == expect_act(1, {16'(63 - s), 16'(s)}), "R9 horizontal clamp",
          actv(1, 1), expect_act(1, {16'(63 - s), 16'(s)}));
      chk(actv(1, 2) == expect_act(2, {16'(s), 16'(63 - s)}), "R9 vertical clamp",
          actv(1, 2), expect_act(2, {16'(s), 16'(63 - s)}));
      rd(ra(1, 1), v);
      chk(v == {16'(63 - s), 16'(s)}, "R9 shadow keeps raw", v, {16'(63 - s), 16'(s)});
    end

    // R4 blanking reload
    keep = actv(0, 4);
    wr(ra(0, 4), 32'h1234_5678);
    wr(8'h00, 32'h2);
    repeat (4) @(negedge clk);
    rd(8'h00, v); chk(v == 2, "R4 armed", v, 2);
    chk(actv(0, 4) == keep, "R4 waits for blank", actv(0, 4), keep);
    vblank = 1;
    @(negedge clk);
    chk(actv(0, 4) == 32'h1234_5678, "R4 copy at blank", actv(0, 4), 32'h1234_5678);
    rd(8'h00, v); chk(v == 0, "R4 bit clears", v, 0);
    wr(ra(0, 4), 32'h0BAD_CAFE);
    wr(8'h00, 32'h2);
    repeat (4) @(negedge clk);
    chk(actv(0, 4) == 32'h1234_5678, "R4 steady high no copy", actv(0, 4), 32'h1234_5678);
    vblank = 0; repeat (2) @(negedge clk);
    vblank = 1; @(negedge clk);
    chk(actv(0, 4) == 32'h0BAD_CAFE, "R4 next rise copies", actv(0, 4), 32'h0BAD_CAFE);
    vblank = 0; @(negedge clk);

    // R6 priority
    wr(ra(0, 6), 32'h0000_0AAA);
    wr(8'h00, 32'h3);
    @(negedge clk);
    rd(8'h00, v); chk(v == 0, "R6 both bits cleared", v, 0);
    chk(actv(0, 6) == 32'h0000_0AAA, "R6 immediate done", actv(0, 6), 32'h0000_0AAA);
    wr(ra(0, 6), 32'h0000_0BBB);
    vblank = 1; @(negedge clk); vblank = 0; @(negedge clk);
    chk(actv(0, 6) == 32'h0000_0AAA, "R6 no blank copy", actv(0, 6), 32'h0000_0AAA);
    wr(8'h00, 32'h2);
    wr(8'h00, 32'h1);
    @(negedge clk);
    rd(8'h00, v); chk(v == 0, "R6 armed blank cancelled", v, 0);
    chk(actv(0, 6) == 32'h0000_0BBB, "R6 later immediate", actv(0, 6), 32'h0000_0BBB);

    // R8 done flag and interrupt
    rd(8'h01, v); chk(v == 1, "R8 flag set", v, 1);
    chk(!irq, "R8 masked", irq, 0);
    wr(8'h02, 32'h1);
    chk(irq, "R8 enabled", irq, 1);
    wr(8'h01, 32'h0);
    rd(8'h01, v); chk(v == 1, "R8 write 0 keeps", v, 1);
    wr(8'h01, 32'h1);
    rd(8'h01, v); chk(v == 0 && !irq, "R8 cleared", {v[30:0], irq}, 0);
    reload_now();
    chk(irq, "R8 set again", irq, 1);
    wr(8'h01, 32'h1);

    // R7 lookup-table protection
    for (int c = 0; c < 4; c++) begin
      wr(ra(0, 0), 32'(c));
      reload_now();
      wr(8'h1A, 32'h5500_0000 | 32'(c));
      chk(lut_we == (c != 3), "R7 lut gate", lut_we, (c != 3));
      if (c != 3) chk(lut_data == (32'h5500_0000 | 32'(c)) && lut_layer == 0, "R7 lut payload",
                      lut_data, 32'h5500_0000 | 32'(c));
      @(negedge clk);
      chk(!lut_we, "R7 one cycle", lut_we, 0);
    end
    wr(ra(0, 0), 32'h0);
    wr(8'h1A, 32'h77);
    chk(!lut_we, "R7 active copy decides", lut_we, 0);
    wr(8'h2A, 32'h88);
    chk(lut_we && lut_layer == 1 && lut_data == 32'h88, "R7 layer1 allowed", {lut_we, lut_layer}, 3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule